// File: doc/BRIEF.md
# Frame Transfer Handshake Controller

This controller moves one frame of samples into external memory on behalf of an accelerator. It waits for the accelerator's input-valid flag and captures the destination base address and the frame length in words. It then issues a single-cycle write command to a memory write engine and passes the frame through as a valid/ready stream with a last marker. After the final beat it waits for the memory side's write-done indication, and then raises a one-cycle next-input pulse to tell the accelerator that the frame is in place.

The sequence is strict: idle, capture, command, stream, completion wait, pulse. The completion wait is bounded by a programmable cycle count. If the wait expires, the controller raises an error flag and returns to idle without pulsing. A zero-length frame skips the command and the stream and goes straight to the pulse.

Top module: `frame_xfer_ctrl`

## Requirements
- R1: After reset, cmd_valid_o, m_tvalid_o, m_tlast_o, src_ready_o, input_next_o and err_o are all low.
- R2: While idle, nothing leaves the block until reg_valid_i is sampled high. Address and size are captured on that edge, and later changes on reg_addr_i and reg_size_i have no effect on the command.
- R3: Exactly two edges after reg_valid_i is sampled, cmd_valid_o is high for one cycle and carries the captured address on cmd_addr_o and the length on cmd_len_o.
- R4: In the stream phase, m_tvalid_o follows src_valid_i and m_tdata_o follows src_data_i. The phase ends after exactly size accepted beats, where a beat is accepted when src_valid_i and m_tready_i are both high.
- R5: m_tlast_o is high during the stream phase only while the beat index, counted from 0, equals size-1.
- R6: src_ready_o equals m_tready_i in the stream phase and is low in every other phase.
- R7: If wr_done_i is sampled high during the completion wait, input_next_o is high in the next cycle and for that cycle only.
- R8: A size of 0 produces no command and no beats. input_next_o pulses in the cycle after the capture phase.
- R9: If wr_done_i stays low for T cycles of the completion wait (T = timeout_cycles_i, with 0 treated as 1), err_o goes high, the controller returns to idle, and no pulse is given.
- R10: If wr_done_i arrives in the last cycle of the wait window, completion wins over the timeout: a pulse is given and err_o stays low.
- R11: err_o holds until the next frame is accepted and clears on the edge that leaves idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Accelerator input-valid flag |
| reg_addr_i | input | 32 | Frame base address |
| reg_size_i | input | 16 | Frame length in words |
| timeout_cycles_i | input | 16 | Completion wait limit in cycles |
| cmd_valid_o | output | 1 | Write command strobe |
| cmd_addr_o | output | 32 | Command address |
| cmd_len_o | output | 16 | Command length in words |
| src_data_i | input | 32 | Frame data from producer |
| src_valid_i | input | 1 | Producer data valid |
| src_ready_o | output | 1 | Backpressure to producer |
| m_tdata_o | output | 32 | Stream data to write engine |
| m_tvalid_o | output | 1 | Stream valid |
| m_tlast_o | output | 1 | Last beat of frame |
| m_tready_i | input | 1 | Write engine ready |
| wr_done_i | input | 1 | Memory write complete |
| input_next_o | output | 1 | Frame ready pulse to accelerator |
| err_o | output | 1 | Completion timeout flag |

## Verification
The last cycle of the completion window is the point where write-done and the timeout can fall in the same cycle. The bench provokes this by delaying write-done by exactly T-1 wait cycles. It expects a next pulse with err_o low, and it then delays by T cycles to expect the error with no pulse. Random frame lengths, limits, done delays and stall patterns on both stream sides surround these directed cases, and each beat's last marker and ready are compared with the bench's own beat count.

// File: rtl/fxc_pkg.sv
package fxc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_CMD, ST_STREAM, ST_WAIT, ST_PULSE
  } fxc_state_e;
endpackage

// File: rtl/fxc_beat_ctr.sv
module fxc_beat_ctr #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         adv_i,
  input  logic [W-1:0] size_i,
  output logic         last_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (adv_i)   cnt_q <= cnt_q + ONE;
  end

  assign last_o = (cnt_q == size_i - ONE);
endmodule

// File: rtl/fxc_watchdog.sv
module fxc_watchdog #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   cnt_p1;

  assign cnt_p1 = {1'b0, cnt_q} + (W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + W'(1);
    else            cnt_q <= '0;
  end

  // limit 0 behaves as 1
  assign expire_o = run_i && (cnt_p1 >= {1'b0, limit_i});
endmodule

// File: rtl/frame_xfer_ctrl.sv
module frame_xfer_ctrl
  import fxc_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int DW = 32,
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_valid_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [SW-1:0] reg_size_i,
  input  logic [TW-1:0] timeout_cycles_i,
  output logic          cmd_valid_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [SW-1:0] cmd_len_o,
  input  logic [DW-1:0] src_data_i,
  input  logic          src_valid_i,
  output logic          src_ready_o,
  output logic [DW-1:0] m_tdata_o,
  output logic          m_tvalid_o,
  output logic          m_tlast_o,
  input  logic          m_tready_i,
  input  logic          wr_done_i,
  output logic          input_next_o,
  output logic          err_o
);
  fxc_state_e state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [SW-1:0] size_q;
  logic          err_q;
  logic          in_stream, beat_fire, beat_last, expire;

  assign in_stream = (state_q == ST_STREAM);
  assign beat_fire = in_stream && src_valid_i && m_tready_i;

  fxc_beat_ctr #(.W(SW)) u_beat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (state_q == ST_CMD),
    .adv_i   (beat_fire),
    .size_i  (size_q),
    .last_o  (beat_last)
  );

  fxc_watchdog #(.W(TW)) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_WAIT),
    .limit_i  (timeout_cycles_i),
    .expire_o (expire)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (reg_valid_i) state_d = ST_READ;
      ST_READ:   state_d = (size_q == '0) ? ST_PULSE : ST_CMD;
      ST_CMD:    state_d = ST_STREAM;
      ST_STREAM: if (beat_fire && beat_last) state_d = ST_WAIT;
      ST_WAIT:   if (wr_done_i) state_d = ST_PULSE;
                 else if (expire) state_d = ST_IDLE;
      ST_PULSE:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      size_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && reg_valid_i) begin
        addr_q <= reg_addr_i;
        size_q <= reg_size_i;
        err_q  <= 1'b0;
      end else if (state_q == ST_WAIT && !wr_done_i && expire) begin
        err_q  <= 1'b1;
      end
    end
  end

  assign cmd_valid_o  = (state_q == ST_CMD);
  assign cmd_addr_o   = addr_q;
  assign cmd_len_o    = size_q;
  assign src_ready_o  = in_stream && m_tready_i;
  assign m_tvalid_o   = in_stream && src_valid_i;
  assign m_tdata_o    = src_data_i;
  assign m_tlast_o    = in_stream && beat_last;
  assign input_next_o = (state_q == ST_PULSE);
  assign err_o        = err_q;

  assert_next_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    input_next_o |=> !input_next_o);
  assert_cmd_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  assert_ready_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o |-> m_tready_i);
  assert_last_ends_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && m_tready_i && m_tlast_o) |=> !m_tvalid_o && !src_ready_o);
  assert_err_no_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !input_next_o);
  assert_cmd_before_beats_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !m_tvalid_o && !input_next_o);
endmodule

// File: tb/frame_xfer_ctrl_bench.sv
module frame_xfer_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_valid = 1'b0;
  logic [31:0] reg_addr = '0;
  logic [15:0] reg_size = '0;
  logic [15:0] tmo = 16'd4;
  logic        cmd_valid;
  logic [31:0] cmd_addr;
  logic [15:0] cmd_len;
  logic [31:0] src_data = '0;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic [31:0] tdata;
  logic        tvalid, tlast;
  logic        tready = 1'b0;
  logic        wr_done = 1'b0;
  logic        nxt, err;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  frame_xfer_ctrl u_frame_xfer_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .reg_valid_i(reg_valid), .reg_addr_i(reg_addr),
    .reg_size_i(reg_size), .timeout_cycles_i(tmo), .cmd_valid_o(cmd_valid),
    .cmd_addr_o(cmd_addr), .cmd_len_o(cmd_len), .src_data_i(src_data),
    .src_valid_i(src_valid), .src_ready_o(src_ready), .m_tdata_o(tdata),
    .m_tvalid_o(tvalid), .m_tlast_o(tlast), .m_tready_i(tready),
    .wr_done_i(wr_done), .input_next_o(nxt), .err_o(err));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_limit(input logic [15:0] t);
    return (t == 16'd0) ? 1 : int'(t);
  endfunction

  // one frame; d = wait cycles before write-done
  task automatic frame(input logic [31:0] a, input logic [15:0] sz,
                       input logic [15:0] t, input int d, input int stall);
    int te;
    te = eff_limit(t);
    tmo = t;
    @(negedge clk);
    reg_valid = 1'b1; reg_addr = a; reg_size = sz;
    @(negedge clk);
    reg_valid = 1'b0; reg_addr = ~a; reg_size = sz + 16'd3;
    #1;
    chk("R11 err cleared on accept", err, 0);
    chk("R3 no cmd in capture", cmd_valid, 0);
    if (sz == 16'd0) begin
      @(negedge clk); #1;
      chk("R8 zero size pulse", nxt, 1);
      chk("R8 zero size no cmd", cmd_valid, 0);
      @(negedge clk); #1;
      chk("R8 pulse single", nxt, 0);
      return;
    end
    @(negedge clk);
    src_valid = 1'b1; tready = 1'b1; #1;
    chk("R3 cmd valid", cmd_valid, 1);
    chk("R2 R3 cmd addr", cmd_addr, a);
    chk("R2 R3 cmd len", cmd_len, sz);
    chk("R6 ready low at cmd", src_ready, 0);
    chk("R4 no tvalid at cmd", tvalid, 0);
    for (int i = 0; i < int'(sz); ) begin
      @(negedge clk);
      src_valid = ($urandom % 100) >= stall;
      tready    = ($urandom % 100) >= stall;
      src_data  = $urandom;
      #1;
      chk("R4 tvalid follows", tvalid, src_valid);
      if (src_valid) chk("R4 tdata follows", tdata, src_data);
      chk("R5 tlast index", tlast, (i == int'(sz) - 1));
      chk("R6 ready follows tready", src_ready, tready);
      if (src_valid && tready) i++;
    end
    for (int j = 0; ; j++) begin
      @(negedge clk);
      if (j == 0) begin
        src_valid = 1'b1; tready = 1'b1; #1;
        chk("R6 ready low after last", src_ready, 0);
        chk("R4 no extra beat", tvalid, 0);
      end
      wr_done = (j == d);
      #1;
      chk("R7 no early pulse", nxt, 0);
      if (j == d) begin
        @(negedge clk);
        wr_done = 1'b0; #1;
        chk(j == te - 1 ? "R10 done wins pulse" : "R7 pulse after done", nxt, 1);
        chk(j == te - 1 ? "R10 no err" : "R7 no err", err, 0);
        @(negedge clk); #1;
        chk("R7 pulse single", nxt, 0);
        break;
      end else if (j == te - 1) begin
        @(negedge clk); #1;
        chk("R9 timeout err", err, 1);
        chk("R9 no pulse", nxt, 0);
        @(negedge clk); #1;
        chk("R9 no late pulse", nxt, 0);
        chk("R11 err held", err, 1);
        break;
      end
    end
    src_valid = 1'b0; tready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    #1;
    chk("R1 cmd", cmd_valid, 0); chk("R1 tvalid", tvalid, 0);
    chk("R1 tlast", tlast, 0);   chk("R1 ready", src_ready, 0);
    chk("R1 next", nxt, 0);      chk("R1 err", err, 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    tready = 1'b1; src_valid = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      chk("R2 idle no cmd", cmd_valid, 0);
      chk("R2 idle no ready", src_ready, 0);
      chk("R2 idle no beat", tvalid, 0);
    end
    src_valid = 1'b0; tready = 1'b0;
    frame(32'h1000_0000, 16'd1, 16'd4, 0, 0);
    frame(32'h2000_0040, 16'd0, 16'd4, 0, 0);
    frame(32'h3000_0100, 16'd3, 16'd4, 3, 30);
    frame(32'h4000_0200, 16'd2, 16'd4, 4, 0);
    frame(32'h5000_0300, 16'd2, 16'd0, 0, 0);
    frame(32'h6000_0400, 16'd1, 16'd0, 1, 0);
    frame(32'h7000_0500, 16'd4, 16'd5, 1, 50);
    for (int k = 0; k < 40; k++) begin
      logic [15:0] sz, t;
      sz = 16'($urandom % 8);
      t  = 16'($urandom % 7);
      frame($urandom, sz, t, int'($urandom % (eff_limit(t) + 2)), int'($urandom % 60));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule